// File: doc/BRIEF.md
# Register Address Auto-Increment Sequencer

This block supplies the register address used during multi-register serial transfers into and out of a twelve-entry register map. When a transaction opens, the serial front end pulses a load strobe together with the address taken from the command byte, and the sequencer takes that value. After that, each time one whole register has been shifted, a transfer-done strobe moves the address on. The size of each step and the point where the address wraps depend on the direction of the transfer and on the addressing policy that is currently programmed.

The map is split by parameters into two types. The lower registers hold data and the upper registers hold control. Each type is split again into groups: the data registers in adjacent pairs and the control registers in blocks of three. A read can stay on one register, loop inside its group, loop inside its type, or run through the whole map. A write either stays on the same register or steps through the whole map. The policy bits are kept inside the block. It captures them when a write completes at the status/communication address. The read-loop field sits at bits 23:22 of the written word and the static-write bit at bit 21.

Top module: `addr_autoinc_seq`

## Requirements
- R1: After synchronous reset `addr` is 0, `rd_loop` is 2'b10 (wrap within type) and `wr_static` is 0 (incremental writes).
- R2: A `cs_load` pulse makes `addr` equal `start_addr` on the next cycle. When `cs_load` and `xfer_done` are high together, the load wins.
- R3: A `start_addr` of 12 or more loads address 0.
- R4: `addr` changes only on a cycle that has `cs_load` or `xfer_done` high.
- R5: Read loop 2'b11: each read transfer adds one to `addr`, and 11 is followed by 0.
- R6: Read loop 2'b10: reads step through the type of the current address, where 0..5 is one type and 6..11 the other, so 5 is followed by 0 and 11 by 6.
- R7: Read loop 2'b01: reads step through the group of the current address. The groups are {0,1}, {2,3}, {4,5}, {6,7,8} and {9,10,11}, and each group's last address is followed by its first.
- R8: Read loop 2'b00: read transfers leave `addr` unchanged.
- R9: With `wr_static`=1 a write transfer leaves `addr` unchanged. With `wr_static`=0 it adds one and wraps 11 to 0.
- R10: A write transfer that completes at address 9 (`xfer_done`=1, `is_write`=1, no load) takes `wr_data[23:22]` into `rd_loop` and `wr_data[21]` into `wr_static`. That same transfer still steps by the old policy. A write at any other address leaves the policy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_load | input | 1 | Transaction start: load `start_addr` |
| start_addr | input | 4 | Address carried by the command |
| xfer_done | input | 1 | One register transfer finished |
| is_write | input | 1 | Current transaction writes (1) or reads (0) |
| wr_data | input | 24 | Word written by the finishing transfer |
| addr | output | 4 | Current register address |
| rd_loop | output | 2 | Programmed read-loop scope |
| wr_static | output | 1 | Programmed static-write policy |

## Verification
The bench drives reads across the last address of every region: 5, 11, the end of a control group and the end of a data pair. A design that used the wrong bounds would step off into the next region or into the addresses past the map. Writes to the status address check that the new policy applies only from the next transfer, so a design that read the policy combinationally from the incoming word would wrap or hold one transfer too early. Tests of an out-of-range start address, of a load arriving on the same cycle as a transfer strobe, and of a write to a non-status address catch designs that load garbage, let the step beat the load, or decode the policy from any address.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

    // Wrap scope for one step; the encoding equals the read-loop field
    typedef enum logic [1:0] {
        LOOP_HOLD  = 2'b00,
        LOOP_GROUP = 2'b01,
        LOOP_TYPE  = 2'b10,
        LOOP_MAP   = 2'b11
    } loop_scope_e;

    typedef struct packed {
        loop_scope_e rd_loop;
        logic        wr_static;
    } seq_mode_t;

    localparam seq_mode_t MODE_RESET = '{rd_loop: LOOP_TYPE, wr_static: 1'b0};

    // Width of the policy field inside the status word
    localparam int MODE_FIELD_W = 3;

    function automatic loop_scope_e pick_scope(input seq_mode_t m, input logic wr);
        loop_scope_e s;
        if (wr) begin
            s = m.wr_static ? LOOP_HOLD : LOOP_MAP;
        end else begin
            s = m.rd_loop;
        end
        return s;
    endfunction

    function automatic seq_mode_t unpack_mode(input logic [MODE_FIELD_W-1:0] f);
        seq_mode_t m;
        m.rd_loop   = loop_scope_e'(f[2:1]);
        m.wr_static = f[0];
        return m;
    endfunction

endpackage

// File: rtl/addr_region_calc.sv
module addr_region_calc
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int NUM_REGS   = 12,
    parameter int TYPE_SPLIT = 6,
    parameter int DATA_GRP   = 2,
    parameter int CTRL_GRP   = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  loop_scope_e       scope,
    output logic [ADDR_W-1:0] region_lo,
    output logic [ADDR_W-1:0] region_hi
);
    localparam int LAST_REG  = NUM_REGS - 1;
    localparam int DATA_LAST = TYPE_SPLIT - 1;

    int a_i;
    int grp_lo_i;
    int grp_hi_i;
    int lo_i;
    int hi_i;

    // Group bounds, split per type
    always_comb begin
        a_i = int'(cur_addr);
        if (a_i < TYPE_SPLIT) begin
            grp_lo_i = (a_i / DATA_GRP) * DATA_GRP;
            grp_hi_i = grp_lo_i + DATA_GRP - 1;
            if (grp_hi_i > DATA_LAST) grp_hi_i = DATA_LAST;
        end else begin
            grp_lo_i = TYPE_SPLIT + ((a_i - TYPE_SPLIT) / CTRL_GRP) * CTRL_GRP;
            grp_hi_i = grp_lo_i + CTRL_GRP - 1;
            if (grp_hi_i > LAST_REG) grp_hi_i = LAST_REG;
        end
    end

    always_comb begin
        unique case (scope)
            LOOP_MAP: begin
                lo_i = 0;
                hi_i = LAST_REG;
            end
            LOOP_TYPE: begin
                if (a_i < TYPE_SPLIT) begin
                    lo_i = 0;
                    hi_i = DATA_LAST;
                end else begin
                    lo_i = TYPE_SPLIT;
                    hi_i = LAST_REG;
                end
            end
            LOOP_GROUP: begin
                lo_i = grp_lo_i;
                hi_i = grp_hi_i;
            end
            default: begin
                lo_i = a_i;
                hi_i = a_i;
            end
        endcase
    end

    assign region_lo = ADDR_W'(lo_i);
    assign region_hi = ADDR_W'(hi_i);

endmodule

// File: rtl/addr_mode_reg.sv
module addr_mode_reg
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int WDATA_W     = 24,
    parameter int STATUS_ADDR = 9,
    parameter int MODE_MSB    = 23
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_load,
    input  logic               xfer_done,
    input  logic               is_write,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]  cur_addr,
    output seq_mode_t          mode
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
    localparam int FIELD_LSB = MODE_MSB - MODE_FIELD_W + 1;

    logic capture;
    assign capture = xfer_done && is_write && !cs_load && (cur_addr == STAT_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
        end else if (capture) begin
            mode <= unpack_mode(wr_data[MODE_MSB:FIELD_LSB]);
        end
    end

endmodule

// File: rtl/addr_step_core.sv
module addr_step_core
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              xfer_done,
    input  loop_scope_e       scope,
    input  logic [ADDR_W-1:0] region_lo,
    input  logic [ADDR_W-1:0] region_hi,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NUM_REGS - 1);

    logic [ADDR_W-1:0] load_val;
    logic [ADDR_W-1:0] step_val;

    assign load_val = (start_addr > LAST_A) ? '0 : start_addr;

    always_comb begin
        if (scope == LOOP_HOLD) begin
            step_val = cur_addr;
        end else if (cur_addr == region_hi) begin
            step_val = region_lo;
        end else begin
            step_val = cur_addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else if (cs_load) begin
            cur_addr <= load_val;
        end else if (xfer_done) begin
            cur_addr <= step_val;
        end
    end

endmodule

// File: rtl/addr_autoinc_seq.sv
module addr_autoinc_seq
    import addr_seq_pkg::*;
#(
    parameter int NUM_REGS    = 12,
    parameter int ADDR_W      = $clog2(NUM_REGS),
    parameter int TYPE_SPLIT  = 6,
    parameter int DATA_GRP    = 2,
    parameter int CTRL_GRP    = 3,
    parameter int STATUS_ADDR = 9,
    parameter int WDATA_W     = 24,
    parameter int MODE_MSB    = 23
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_load,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               xfer_done,
    input  logic               is_write,
    input  logic [WDATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0]  addr,
    output logic [1:0]         rd_loop,
    output logic               wr_static
);
    seq_mode_t         mode;
    loop_scope_e       scope;
    logic [ADDR_W-1:0] region_lo;
    logic [ADDR_W-1:0] region_hi;
    logic [ADDR_W-1:0] cur_addr;

    assign scope = pick_scope(mode, is_write);

    addr_mode_reg #(
        .ADDR_W      (ADDR_W),
        .WDATA_W     (WDATA_W),
        .STATUS_ADDR (STATUS_ADDR),
        .MODE_MSB    (MODE_MSB)
    ) mode_i (
        .clk       (clk),
        .rst       (rst),
        .cs_load   (cs_load),
        .xfer_done (xfer_done),
        .is_write  (is_write),
        .wr_data   (wr_data),
        .cur_addr  (cur_addr),
        .mode      (mode)
    );

    addr_region_calc #(
        .ADDR_W     (ADDR_W),
        .NUM_REGS   (NUM_REGS),
        .TYPE_SPLIT (TYPE_SPLIT),
        .DATA_GRP   (DATA_GRP),
        .CTRL_GRP   (CTRL_GRP)
    ) region_i (
        .cur_addr  (cur_addr),
        .scope     (scope),
        .region_lo (region_lo),
        .region_hi (region_hi)
    );

    addr_step_core #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) step_i (
        .clk        (clk),
        .rst        (rst),
        .cs_load    (cs_load),
        .start_addr (start_addr),
        .xfer_done  (xfer_done),
        .scope      (scope),
        .region_lo  (region_lo),
        .region_hi  (region_hi),
        .cur_addr   (cur_addr)
    );

    assign addr      = cur_addr;
    assign rd_loop   = mode.rd_loop;
    assign wr_static = mode.wr_static;

endmodule

// File: rtl/addr_autoinc_seq_chk.sv
module addr_autoinc_seq_chk #(
    parameter int NUM_REGS    = 12,
    parameter int ADDR_W      = 4,
    parameter int TYPE_SPLIT  = 6,
    parameter int STATUS_ADDR = 9,
    parameter int WDATA_W     = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_load,
    input logic [ADDR_W-1:0]  start_addr,
    input logic               xfer_done,
    input logic               is_write,
    input logic [WDATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0]  addr,
    input logic [1:0]         rd_loop,
    input logic               wr_static
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] DLAST  = ADDR_W'(TYPE_SPLIT - 1);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    logic rd_step;
    logic wr_step;
    assign rd_step = xfer_done && !cs_load && !is_write;
    assign wr_step = xfer_done && !cs_load && is_write;

    AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
        (cs_load && start_addr <= LAST_A) |=> addr == $past(start_addr)); // R2
    AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cs_load && start_addr > LAST_A) |=> addr == '0); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_load && !xfer_done) |=> $stable(addr)); // R4
    AST_MAP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (rd_step && rd_loop == 2'b11 && addr == LAST_A) |=> addr == '0); // R5
    AST_TYPE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (rd_step && rd_loop == 2'b10 && addr == DLAST) |=> addr == '0); // R6
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_step && rd_loop == 2'b00) |=> $stable(addr)); // R8
    AST_WRITE_STATIC: assert property (@(posedge clk) disable iff (rst)
        (wr_step && wr_static) |=> $stable(addr)); // R9
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_step && addr == STAT_A) |=> ($stable(rd_loop) && $stable(wr_static))); // R10
    AST_ADDR_IN_MAP: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST_A); // R5

endmodule

bind addr_autoinc_seq addr_autoinc_seq_chk #(
    .NUM_REGS    (NUM_REGS),
    .ADDR_W      (ADDR_W),
    .TYPE_SPLIT  (TYPE_SPLIT),
    .STATUS_ADDR (STATUS_ADDR),
    .WDATA_W     (WDATA_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_load    (cs_load),
    .start_addr (start_addr),
    .xfer_done  (xfer_done),
    .is_write   (is_write),
    .wr_data    (wr_data),
    .addr       (addr),
    .rd_loop    (rd_loop),
    .wr_static  (wr_static)
);

// File: tb/addr_autoinc_seq_tb.sv
module addr_autoinc_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    // {load, start[3:0], xfer, write, policy[2:0], expected addr[3:0]}
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 4'd4,  1'b0, 1'b0, 3'd0, 4'd4},   // load 4
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd5},   // R6 type step
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd0},   // R6 5 -> 0
        {1'b1, 4'd10, 1'b0, 1'b0, 3'd0, 4'd10},
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd11},
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd6},   // R6 11 -> 6
        {1'b1, 4'd9,  1'b0, 1'b0, 3'd0, 4'd9},
        {1'b0, 4'd0,  1'b1, 1'b1, 3'd3, 4'd10},  // R10 old policy steps, new = group/static
        {1'b1, 4'd6,  1'b0, 1'b0, 3'd0, 4'd6},
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd7},   // R7
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd8},
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd6},   // R7 8 -> 6
        {1'b1, 4'd3,  1'b0, 1'b0, 3'd0, 4'd3},
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd2},   // R7 3 -> 2
        {1'b0, 4'd0,  1'b1, 1'b1, 3'd0, 4'd2},   // R9 static write; R10 addr 2 no capture
        {1'b1, 4'd9,  1'b0, 1'b0, 3'd0, 4'd9},
        {1'b0, 4'd0,  1'b1, 1'b1, 3'd7, 4'd9},   // R10 policy kept, static; new = map/static
        {1'b0, 4'd0,  1'b1, 1'b1, 3'd6, 4'd9},   // static still; new = map/incremental
        {1'b0, 4'd0,  1'b1, 1'b1, 3'd6, 4'd10},  // R9 incremental write
        {1'b1, 4'd11, 1'b0, 1'b0, 3'd0, 4'd11},
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd0},   // R5 11 -> 0
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd1},   // R5
        {1'b1, 4'd9,  1'b0, 1'b0, 3'd0, 4'd9},
        {1'b0, 4'd0,  1'b1, 1'b1, 3'd0, 4'd10},  // R10 new = hold/incremental
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd10},  // R8 hold
        {1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 4'd10},  // R8 hold
        {1'b1, 4'd15, 1'b0, 1'b0, 3'd0, 4'd0},   // R3 out of range
        {1'b1, 4'd5,  1'b1, 1'b0, 3'd0, 4'd5}    // R2 load beats step
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_load = 1'b0;
    logic [3:0]  start_addr = '0;
    logic        xfer_done = 1'b0;
    logic        is_write = 1'b0;
    logic [23:0] wr_data = '0;
    logic [3:0]  addr;
    logic [1:0]  rd_loop;
    logic        wr_static;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_autoinc_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .cs_load    (cs_load),
        .start_addr (start_addr),
        .xfer_done  (xfer_done),
        .is_write   (is_write),
        .wr_data    (wr_data),
        .addr       (addr),
        .rd_loop    (rd_loop),
        .wr_static  (wr_static)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, release and sample
    task automatic apply(input logic ld, input logic [3:0] st, input logic xf,
                         input logic wr, input logic [2:0] pol);
        cs_load    = ld;
        start_addr = st;
        xfer_done  = xf;
        is_write   = wr;
        wr_data    = {pol, 21'h0};
        @(negedge clk);
        cs_load   = 1'b0;
        xfer_done = 1'b0;
        is_write  = 1'b0;
        wr_data   = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 addr", addr, 4'd0);
        check("R1 rd_loop", {2'b0, rd_loop}, 4'd2);
        check("R1 wr_static", {3'b0, wr_static}, 4'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][13], VEC[i][12:9], VEC[i][8], VEC[i][7], VEC[i][6:4]);
            check($sformatf("R2-vector %0d", i), addr, VEC[i][3:0]);
        end

        // R4: idle cycles leave the address
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R4 idle", addr, 4'd5);
        end

        // R10: a read at the status address does not touch the policy
        apply(1'b1, 4'd9, 1'b0, 1'b0, 3'd0);
        apply(1'b0, 4'd0, 1'b1, 1'b0, 3'd7);
        check("R10 read no capture", {2'b0, rd_loop}, 4'd0);
        check("R8 hold at 9", addr, 4'd9);

        // R1: reset in mid-run restores defaults
        do_reset();
        check("R1 addr again", addr, 4'd0);
        check("R1 rd_loop again", {2'b0, rd_loop}, 4'd2);
        check("R1 wr_static again", {3'b0, wr_static}, 4'd0);

        // R6 default type loop after reset, and R9 incremental write wrap
        apply(1'b1, 4'd5, 1'b0, 1'b0, 3'd0);
        apply(1'b0, 4'd0, 1'b1, 1'b0, 3'd0);
        check("R6 default 5->0", addr, 4'd0);
        apply(1'b1, 4'd11, 1'b0, 1'b0, 3'd0);
        apply(1'b0, 4'd0, 1'b1, 1'b1, 3'd0);
        check("R9 write 11->0", addr, 4'd0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule